// File: doc/BRIEF.md
# Post-Configuration Startup Sequencer

After a programmable device has taken in its configuration data, this block walks it through a fixed ladder of seven startup phases, numbered 0 to 6. It moves one phase per clock, and it can park in chosen phases while it waits for external conditions. Three device-wide controls are tied to phases by static settings. They are the DONE indication, the release of the global I/O tri-state and the global write enable; while the write enable is low, no memory can be written or read. A fourth output, a sticky flag, reports that the whole sequence is over.

Each of the two dependent controls, the tri-state release and the write enable, can pick its own phase. It can instead follow DONE, or it can be held back for good. DONE itself can pick a phase or be held back, and an optional short pipeline can delay it. Two stall points can be placed on any phase. One waits for clock lock. The other waits for the I/O impedance match, and it has an automatic mode that stalls in phase 2 only when impedance-controlled I/O is in use. Because of these stalls, the total startup length depends on the environment. The clock must keep running until DONE is high.

All settings are plain static inputs. No data stream passes through the block, so there is no valid/ready handshake on any pin.

Top module: `startup_seq`

## Requirements
- R1: With `rst` high at a clock edge, all four outputs are 0 after that edge. After reset the block sits idle in phase 0 with all outputs 0 until `start` is sampled high.
- R2: The cycle in which `start` is sampled is cycle 0, and phase 0 is current after it. With no stall the phase steps by one per cycle. An output tied to phase N (1..6) goes high N+1 cycles after `start` is sampled.
- R3: `cfg_done_sel` codes 1..6 select the DONE phase (default 4). Codes 0 and 7 mean Keep, and DONE then never goes high.
- R4: When `done_pipe_en` is 1, DONE rises PIPE_DEPTH cycles later than it would with the pipe off.
- R5: `cfg_gts_sel` and `cfg_gwe_sel` use codes 1..6 for a phase (defaults 5 and 6), 0 for follow-DONE and 7 for Keep. A follow-DONE output rises in the same cycle as `done_o`, after any pipe delay. It never rises if DONE is Keep.
- R6: `cfg_lock_sel` codes 0..6 name a phase, and the sequencer stays in that phase while `pll_lock` is 0. Code 7 means no wait.
- R7: `cfg_match_sel` codes 0..6 name a phase in which the sequencer waits for `imp_match`, and code 7 means no wait. Codes 8..15 are Auto: they act as phase 2 when `dci_used` is 1, and as no wait otherwise.
- R8: If the lock wait and the match wait name the same phase, the sequencer leaves that phase only once both inputs are 1.
- R9: `complete_o` rises one cycle after both of these hold: phase 6 has been left, and every output that can ever rise has risen. Once high it stays high, and at that point every non-Keep output is high.
- R10: Outputs that have risen stay high until reset. `start` has no effect while a sequence is running or after it has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse: configuration data fully loaded |
| pll_lock | input | 1 | Clock lock condition |
| imp_match | input | 1 | Impedance match condition |
| dci_used | input | 1 | Impedance-controlled I/O present (resolves Auto) |
| done_pipe_en | input | 1 | Enable the DONE delay pipeline |
| cfg_done_sel | input | 3 | DONE phase: 1..6, 0/7 Keep |
| cfg_gts_sel | input | 3 | Tri-state release phase: 1..6, 0 follow DONE, 7 Keep |
| cfg_gwe_sel | input | 3 | Write enable phase: 1..6, 0 follow DONE, 7 Keep |
| cfg_lock_sel | input | 3 | Lock-wait phase 0..6, 7 no wait |
| cfg_match_sel | input | 4 | Match-wait phase 0..6, 7 no wait, 8..15 Auto |
| done_o | output | 1 | DONE indication |
| gts_rel_o | output | 1 | Global I/O tri-state released |
| gwe_o | output | 1 | Global write enable |
| complete_o | output | 1 | Sticky sequence-complete flag |

## Verification
The assertions assume three things about the inputs. The configuration selects stay fixed from reset until the sequence completes. `pll_lock` and `imp_match` are already synchronous to `clk`. `start` comes as a single pulse. The stimulus follows these rules: it programs every select while reset is held and changes nothing until the next reset. It drives the two condition inputs away from the clock edge as a step that starts at a chosen cycle and never falls. It raises `start` for exactly one cycle, and the only extra pulses are the ones placed deliberately to show that they are ignored.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] PH_LAST    = 3'd6;
  localparam logic [PH_W-1:0] SEL_FOLLOW = 3'd0;
  localparam logic [PH_W-1:0] SEL_KEEP   = 3'd7;
  localparam logic [PH_W-1:0] WAIT_NONE  = 3'd7;
  localparam logic [PH_W-1:0] AUTO_PH    = 3'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_t;

  // Auto match mode: phase 2 if impedance-controlled I/O is present, else no wait
  function automatic logic [PH_W-1:0] resolve_match(input logic [PH_W:0] code,
                                                    input logic dci);
    if (code[PH_W]) return dci ? AUTO_PH : WAIT_NONE;
    return code[PH_W-1:0];
  endfunction
endpackage

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr
  import startup_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            lock_in,
  input  logic            match_in,
  input  logic [PH_W-1:0] lock_ph,
  input  logic [PH_W-1:0] match_ph,
  output logic            running,
  output logic            finished,
  output logic [PH_W-1:0] phase
);
  seq_state_t      st_q;
  logic [PH_W-1:0] ph_q;
  logic            stall;

  // a wait code of 7 never equals a live phase, so it never stalls
  always_comb
    stall = ((lock_ph == ph_q) && !lock_in) || ((match_ph == ph_q) && !match_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q <= ST_RUN;
          ph_q <= '0;
        end
        ST_RUN: if (!stall) begin
          if (ph_q == PH_LAST) st_q <= ST_FIN;
          else                 ph_q <= ph_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign running  = (st_q == ST_RUN);
  assign finished = (st_q == ST_FIN);
  assign phase    = ph_q;
endmodule

// File: rtl/startup_event.sv
module startup_event
  import startup_pkg::*;
#(
  parameter bit ALLOW_FOLLOW = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            running,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] sel,
  input  logic            done_in,
  output logic            act,
  output logic            enabled
);
  logic hit_q;
  logic is_phase;
  logic follow;

  assign is_phase = (sel != SEL_FOLLOW) && (sel != SEL_KEEP);
  assign follow   = ALLOW_FOLLOW && (sel == SEL_FOLLOW);

  always_ff @(posedge clk) begin
    if (rst)                                    hit_q <= 1'b0;
    else if (running && is_phase && phase == sel) hit_q <= 1'b1;
  end

  assign act     = follow ? done_in : hit_q;
  assign enabled = is_phase || follow;
endmodule

// File: rtl/startup_done_pipe.sv
module startup_done_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int LAST = DEPTH - 1;
  logic [LAST:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = en ? sr_q[LAST] : d;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       pll_lock,
  input  logic       imp_match,
  input  logic       dci_used,
  input  logic       done_pipe_en,
  input  logic [2:0] cfg_done_sel,
  input  logic [2:0] cfg_gts_sel,
  input  logic [2:0] cfg_gwe_sel,
  input  logic [2:0] cfg_lock_sel,
  input  logic [3:0] cfg_match_sel,
  output logic       done_o,
  output logic       gts_rel_o,
  output logic       gwe_o,
  output logic       complete_o
);
  localparam int N_DEP = 2;

  logic            seq_running, seq_fin;
  logic [PH_W-1:0] seq_phase;
  logic [PH_W-1:0] match_wait_ph;
  logic            done_raw, done_en;
  logic [PH_W-1:0] dep_sel [N_DEP];
  logic [N_DEP-1:0] dep_act, dep_en, dep_need;
  logic            all_in;
  logic            cmp_q;

  assign match_wait_ph = resolve_match(cfg_match_sel, dci_used);

  startup_phase_ctr u_ctr (
    .clk(clk), .rst(rst), .start(start),
    .lock_in(pll_lock), .match_in(imp_match),
    .lock_ph(cfg_lock_sel), .match_ph(match_wait_ph),
    .running(seq_running), .finished(seq_fin), .phase(seq_phase)
  );

  startup_event #(.ALLOW_FOLLOW(1'b0)) u_done_ev (
    .clk(clk), .rst(rst), .running(seq_running), .phase(seq_phase),
    .sel(cfg_done_sel), .done_in(1'b0), .act(done_raw), .enabled(done_en)
  );

  startup_done_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst(rst), .en(done_pipe_en), .d(done_raw), .q(done_o)
  );

  assign dep_sel[0] = cfg_gts_sel;
  assign dep_sel[1] = cfg_gwe_sel;

  generate
    for (genvar gi = 0; gi < N_DEP; gi++) begin : g_dep
      startup_event #(.ALLOW_FOLLOW(1'b1)) u_ev (
        .clk(clk), .rst(rst), .running(seq_running), .phase(seq_phase),
        .sel(dep_sel[gi]), .done_in(done_o),
        .act(dep_act[gi]), .enabled(dep_en[gi])
      );
      // following a DONE that is kept back can never happen
      assign dep_need[gi] = dep_en[gi] && !((dep_sel[gi] == SEL_FOLLOW) && !done_en);
    end
  endgenerate

  assign gts_rel_o = dep_act[0];
  assign gwe_o     = dep_act[1];

  assign all_in = (!done_en || done_o) && (&(dep_act | ~dep_need));

  always_ff @(posedge clk) begin
    if (rst)                  cmp_q <= 1'b0;
    else if (seq_fin && all_in) cmp_q <= 1'b1;
  end

  assign complete_o = cmp_q;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_lock,
  input logic       imp_match,
  input logic [2:0] done_sel,
  input logic       done_o,
  input logic       gts_rel_o,
  input logic       gwe_o,
  input logic       complete_o,
  input logic       running,
  input logic [2:0] phase,
  input logic [2:0] lock_ph,
  input logic [2:0] match_ph
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(done_o || gts_rel_o || gwe_o || complete_o));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    running && $past(running) |-> (phase == $past(phase)) || (phase == $past(phase) + 3'd1));

  a_r6_lock_hold: assert property (@(posedge clk) disable iff (rst)
    running && (lock_ph == phase) && !pll_lock |=> running && (phase == $past(phase)));

  a_r7_match_hold: assert property (@(posedge clk) disable iff (rst)
    running && (match_ph == phase) && !imp_match |=> running && (phase == $past(phase)));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  a_r10_gts_sticky: assert property (@(posedge clk) disable iff (rst)
    gts_rel_o |=> gts_rel_o);

  a_r10_gwe_sticky: assert property (@(posedge clk) disable iff (rst)
    gwe_o |=> gwe_o);

  a_r9_complete_sticky: assert property (@(posedge clk) disable iff (rst)
    complete_o |=> complete_o);

  a_r9_complete_has_done: assert property (@(posedge clk) disable iff (rst)
    complete_o && (done_sel != 3'd0) && (done_sel != 3'd7) |-> done_o);

  a_r9_complete_not_running: assert property (@(posedge clk) disable iff (rst)
    complete_o |-> !running);
endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk(clk), .rst(rst), .pll_lock(pll_lock), .imp_match(imp_match),
  .done_sel(cfg_done_sel), .done_o(done_o), .gts_rel_o(gts_rel_o),
  .gwe_o(gwe_o), .complete_o(complete_o), .running(seq_running),
  .phase(seq_phase), .lock_ph(cfg_lock_sel), .match_ph(match_wait_ph)
);

// File: tb/test_startup_seq.sv
`timescale 1ns/100ps
module test_startup_seq;
  localparam int D = 2;
  localparam int WAIT_CYC = 70;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, pll_lock = 1'b0, imp_match = 1'b0, dci_used = 1'b0, done_pipe_en = 1'b0;
  logic [2:0] cfg_done_sel = 3'd4, cfg_gts_sel = 3'd5, cfg_gwe_sel = 3'd6, cfg_lock_sel = 3'd7;
  logic [3:0] cfg_match_sel = 4'd8;
  logic done_o, gts_rel_o, gwe_o, complete_o;

  int tests = 0, fails = 0;
  int cyc = 0, t0 = 0;
  bit armed = 1'b0;
  int lock_at = 0, match_at = 0;
  int rec [4];

  typedef struct { int id; int t; string req; } exp_t;
  exp_t sb [$];
  string onames [4] = '{"done", "gts_rel", "gwe", "complete"};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  startup_seq #(.PIPE_DEPTH(D)) i_startup_seq (
    .clk(clk), .rst(rst), .start(start), .pll_lock(pll_lock), .imp_match(imp_match),
    .dci_used(dci_used), .done_pipe_en(done_pipe_en), .cfg_done_sel(cfg_done_sel),
    .cfg_gts_sel(cfg_gts_sel), .cfg_gwe_sel(cfg_gwe_sel), .cfg_lock_sel(cfg_lock_sel),
    .cfg_match_sel(cfg_match_sel), .done_o(done_o), .gts_rel_o(gts_rel_o),
    .gwe_o(gwe_o), .complete_o(complete_o)
  );

  // monitor: drives the condition steps and records first-rise cycles
  always @(negedge clk) begin
    if (armed) begin
      int k;
      logic [3:0] o;
      k = cyc - t0;
      pll_lock  = (k >= lock_at);
      imp_match = (k >= match_at);
      o = {complete_o, gwe_o, gts_rel_o, done_o};
      for (int i = 0; i < 4; i++) if (rec[i] < 0 && o[i]) rec[i] = k;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model of the startup ladder
  function automatic void predict(int dsel, int gsel, int wsel, int lsel, int msel,
                                  bit dci, bit pipe, int lat, int mat, output int t [4]);
    int first [7];
    int p, tt, fin, lph, mph, tdone;
    bit stall;
    for (int i = 0; i < 7; i++) first[i] = -1;
    lph = lsel;
    mph = (msel >= 8) ? (dci ? 2 : 7) : msel;
    p = 0; tt = 0; fin = -1;
    while (fin < 0 && tt < 1000) begin
      if (first[p] < 0) first[p] = tt;
      stall = (lph == p && tt < lat) || (mph == p && tt < mat);
      tt++;
      if (!stall) begin
        if (p == 6) fin = tt;
        else p++;
      end
    end
    tdone = (dsel >= 1 && dsel <= 6) ? first[dsel] + 1 + (pipe ? D : 0) : -1;
    t[0] = tdone;
    t[1] = (gsel >= 1 && gsel <= 6) ? first[gsel] + 1 : (gsel == 0 ? tdone : -1);
    t[2] = (wsel >= 1 && wsel <= 6) ? first[wsel] + 1 : (wsel == 0 ? tdone : -1);
    t[3] = fin;
    for (int i = 0; i < 3; i++) if (t[i] > t[3]) t[3] = t[i];
    t[3] = t[3] + 1;
  endfunction

  task automatic do_reset();
    armed = 1'b0;
    rst = 1'b1;
    start = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic kick();
    @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    t0 = cyc;
    armed = 1'b1;
  endtask

  task automatic run_case(string req, int dsel, int gsel, int wsel, int lsel, int msel,
                          bit dci, bit pipe, int lat, int mat, int extra_at);
    int t [4];
    armed = 1'b0;
    rst = 1'b1;
    cfg_done_sel = 3'(dsel); cfg_gts_sel = 3'(gsel); cfg_gwe_sel = 3'(wsel);
    cfg_lock_sel = 3'(lsel); cfg_match_sel = 4'(msel);
    dci_used = dci; done_pipe_en = pipe;
    pll_lock = 1'b0; imp_match = 1'b0;
    lock_at = lat; match_at = mat;
    for (int i = 0; i < 4; i++) rec[i] = -1;
    do_reset();
    predict(dsel, gsel, wsel, lsel, msel, dci, pipe, lat, mat, t);
    for (int i = 0; i < 3; i++) sb.push_back('{i, t[i], req});
    sb.push_back('{3, t[3], "R9"});
    kick();
    if (extra_at > 0) begin
      repeat (extra_at) @(posedge clk);
      #1 start = 1'b1;          // R10: ignored while running
      @(posedge clk);
      #1 start = 1'b0;
      repeat (WAIT_CYC - extra_at - 1) @(posedge clk);
    end else begin
      repeat (WAIT_CYC) @(posedge clk);
    end
    #1 armed = 1'b0;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, {req, " rise cycle of ", onames[e.id]}, rec[e.id], e.t);
    end
  endtask

  initial begin
    #(5ns * 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1", "reset done", done_o, 0);
    check("R1", "reset gts", gts_rel_o, 0);
    check("R1", "reset gwe", gwe_o, 0);
    check("R1", "reset complete", complete_o, 0);

    run_case("R2", 4, 5, 6, 7, 8, 0, 0, 0, 0, 0);     // defaults
    run_case("R4", 4, 5, 6, 7, 8, 0, 1, 0, 0, 0);     // pipe on
    run_case("R4", 6, 5, 6, 7, 8, 0, 1, 0, 0, 0);     // pipe, late DONE
    run_case("R5", 2, 0, 0, 7, 8, 0, 1, 0, 0, 0);     // both follow DONE
    run_case("R3", 7, 1, 7, 7, 8, 0, 0, 0, 0, 0);     // DONE keep (code 7)
    run_case("R3", 0, 0, 3, 7, 8, 0, 0, 0, 0, 0);     // DONE keep (code 0), follow never
    run_case("R6", 4, 5, 6, 3, 8, 0, 0, 20, 0, 5);    // lock stall + R10 extra start
    run_case("R6", 4, 5, 6, 0, 7, 0, 0, 5, 0, 0);     // lock stall in phase 0
    run_case("R7", 4, 5, 6, 7, 8, 1, 0, 0, 15, 0);    // Auto with impedance I/O
    run_case("R7", 4, 5, 6, 7, 8, 0, 0, 0, 40, 0);    // Auto without: no stall
    run_case("R7", 3, 5, 6, 7, 5, 0, 0, 0, 12, 0);    // explicit match phase
    run_case("R8", 4, 5, 6, 4, 4, 0, 0, 10, 25, 0);   // shared phase, match last
    run_case("R8", 4, 5, 6, 4, 4, 0, 0, 30, 8, 0);    // shared phase, lock last

    // R10: start after completion changes nothing
    run_case("R2", 6, 5, 6, 7, 8, 0, 1, 0, 0, 0);
    kick();
    armed = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R10", "done after late start", done_o, 1);
    check("R10", "gts after late start", gts_rel_o, 1);
    check("R10", "gwe after late start", gwe_o, 1);
    check("R10", "complete after late start", complete_o, 1);

    // R1: reset in mid-run clears everything, then idle without start
    cfg_done_sel = 3'd1; cfg_gts_sel = 3'd2; cfg_gwe_sel = 3'd3;
    cfg_lock_sel = 3'd7; cfg_match_sel = 4'd7; done_pipe_en = 1'b0;
    do_reset();
    kick();
    armed = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "done after mid-run reset", done_o, 0);
    check("R1", "gts after mid-run reset", gts_rel_o, 0);
    check("R1", "gwe after mid-run reset", gwe_o, 0);
    repeat (15) @(posedge clk);
    @(negedge clk);
    check("R1", "idle done without start", done_o, 0);
    check("R1", "idle complete without start", complete_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule